// File: doc/BRIEF.md
# Low-Speed Clock Divider Chain

This block takes one fast reference clock and derives from it a set of slower rates: three fixed peripheral rates (serial-port baud base, interval-timer base, video-synthesiser reference), a quarter-rate tick, and a low-speed processor rate picked by a two-bit select. Every derived rate comes out as a clock-enable pulse in the reference domain. A pulse is one reference cycle wide, so downstream logic stays on the one reference clock and needs no generated clock nets.

With a 36.864 MHz reference, the outputs are as follows. The serial base divides by 20 (1.8432 MHz). The timer base divides by 31 (about 1.1892 MHz). The video reference divides by 18 (2.048 MHz). The quarter tick divides by 4 (9.216 MHz). The processor rate divides by 8, 16, 32 or 64 (4.608, 2.304, 1.152 or 0.576 MHz). A run input gates the whole chain. A new processor-rate select waits for the end of the current 64-cycle frame, so the processor never sees a short period.

Top module: `lsclk_divchain`

## Requirements
- R1: While `rst` is high at a rising edge, every tick output is low after that edge, and all division state returns to its start. The active processor rate returns to code 0.
- R2: Count k as the number of rising edges since reset at which `run` was high. Then `uart_tick` is high after the k-th such edge exactly when k is a multiple of 20.
- R3: `timer_tick` is high after the k-th enabled edge exactly when k is a multiple of 31.
- R4: `vref_tick` is high after the k-th enabled edge exactly when k is a multiple of 18.
- R5: `quarter_tick` is high after the k-th enabled edge exactly when k is a multiple of 4.
- R6: The active rate code c (0, 1, 2, 3) makes `cpu_tick` high after the k-th enabled edge exactly when k is a multiple of 8, 16, 32 or 64 respectively.
- R7: The value of `rate_sel` becomes the active code only at an enabled edge where k is a multiple of 64. It then governs edges from k+1 onward. At all other edges `rate_sel` has no effect on `cpu_tick`.
- R8: At an edge where `run` is low, every tick output goes low and k does not advance. The counting phase of every divider is held.
- R9: Every tick output is high for exactly one reference cycle per output period. It is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Chain enable; low freezes all counters |
| rate_sel | input | 2 | Requested processor rate code (0: /8, 1: /16, 2: /32, 3: /64) |
| uart_tick | output | 1 | Serial baud-base enable, reference /20 |
| timer_tick | output | 1 | Timer-base enable, reference /31 |
| vref_tick | output | 1 | Video reference enable, reference /18 |
| quarter_tick | output | 1 | Quarter-rate enable, reference /4 |
| cpu_tick | output | 1 | Selected low-speed processor enable |

## Verification
The embedded assertions check several properties on every cycle:
- every tick is one cycle wide;
- counters stay below their modulus and freeze while `run` is low;
- ticks drop when the chain is stopped;
- the active rate code changes only at the end of a 64-cycle frame.

What those properties cannot show is that each output lands on the right edge. That needs the bench's scoreboard: a model counts enabled edges and predicts every tick. The model also decides which `rate_sel` value must be captured at a frame boundary and which mid-frame changes must be ignored. Pauses in `run` that split a period, and a reset in the middle of a run, are exercised by the bench scenarios as well.

// File: rtl/lsdiv_pkg.sv
package lsdiv_pkg;
  // Default moduli for the fixed outputs, relative to the reference
  localparam int UART_DIV_DEF  = 20;
  localparam int TIMER_DIV_DEF = 31;
  localparam int VREF_DIV_DEF  = 18;
  // Processor rate: code 0 divides by 2**CPU_BASE_LOG2_DEF, each code step doubles
  localparam int CPU_BASE_LOG2_DEF = 3;
  localparam int RATE_SEL_W_DEF    = 2;
  localparam int QTR_LOG2_DEF      = 2;

  typedef enum logic [1:0] {
    RATE_FAST  = 2'd0,
    RATE_HALF  = 2'd1,
    RATE_QUART = 2'd2,
    RATE_SLOW  = 2'd3
  } rate_code_e;
endpackage

// File: rtl/lsdiv_modulo_tick.sv
module lsdiv_modulo_tick #(
  parameter int DIV = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= run && (cnt == LAST);
      if (run) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  // R8
  stopped_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!tick && $stable(cnt)));
  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/lsdiv_cpu_rate.sv
module lsdiv_cpu_rate #(
  parameter int BASE_LOG2 = 3,
  parameter int SEL_W     = 2,
  parameter int QTR_LOG2  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] rate_sel,
  output logic             cpu_tick,
  output logic             qtr_tick
);
  // Frame counter spans the slowest selectable period
  localparam int CW = BASE_LOG2 + (1 << SEL_W) - 1;

  logic [CW-1:0]    cnt;
  logic [SEL_W-1:0] sel_q;
  logic [CW-1:0]    mask;
  logic             at_top;

  assign at_top = &cnt;

  always_comb begin
    for (int i = 0; i < CW; i++) begin
      mask[i] = (i < BASE_LOG2 + int'(sel_q));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      sel_q    <= '0;
      cpu_tick <= 1'b0;
      qtr_tick <= 1'b0;
    end else begin
      cpu_tick <= run && ((cnt & mask) == mask);
      qtr_tick <= run && (&cnt[QTR_LOG2-1:0]);
      if (run) begin
        cnt <= cnt + 1'b1;
        if (at_top) sel_q <= rate_sel;
      end
    end
  end

  // R7
  sel_at_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_q != $past(sel_q)) |-> $past(run && at_top));
  // R9
  cpu_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_tick |=> !cpu_tick);
  // R9
  qtr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    qtr_tick |=> !qtr_tick);
  // R8
  frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> ($stable(cnt) && !cpu_tick && !qtr_tick));
endmodule

// File: rtl/lsclk_divchain.sv
module lsclk_divchain
  import lsdiv_pkg::*;
#(
  parameter int UART_DIV  = UART_DIV_DEF,
  parameter int TIMER_DIV = TIMER_DIV_DEF,
  parameter int VREF_DIV  = VREF_DIV_DEF,
  parameter int CPU_BASE_LOG2 = CPU_BASE_LOG2_DEF,
  parameter int QTR_LOG2  = QTR_LOG2_DEF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] rate_sel,
  output logic       uart_tick,
  output logic       timer_tick,
  output logic       vref_tick,
  output logic       quarter_tick,
  output logic       cpu_tick
);
  localparam int NFIX = 3;
  localparam int FIX_DIV [NFIX] = '{UART_DIV, TIMER_DIV, VREF_DIV};

  logic [NFIX-1:0] fix_tick;

  for (genvar g = 0; g < NFIX; g++) begin : g_fixed
    lsdiv_modulo_tick #(.DIV(FIX_DIV[g])) u_div (
      .clk  (clk),
      .rst  (rst),
      .run  (run),
      .tick (fix_tick[g])
    );
  end

  assign uart_tick  = fix_tick[0];
  assign timer_tick = fix_tick[1];
  assign vref_tick  = fix_tick[2];

  lsdiv_cpu_rate #(
    .BASE_LOG2 (CPU_BASE_LOG2),
    .SEL_W     (RATE_SEL_W_DEF),
    .QTR_LOG2  (QTR_LOG2)
  ) u_cpu (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .rate_sel (rate_sel),
    .cpu_tick (cpu_tick),
    .qtr_tick (quarter_tick)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !(uart_tick || timer_tick || vref_tick || quarter_tick || cpu_tick));
endmodule

// File: tb/lsclk_divchain_bench.sv
module lsclk_divchain_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic uart_tick, timer_tick, vref_tick, quarter_tick, cpu_tick;

  always #10 clk = ~clk;

  lsclk_divchain u_lsclk_divchain (
    .clk(clk), .rst(rst), .run(run), .rate_sel(rate_sel),
    .uart_tick(uart_tick), .timer_tick(timer_tick), .vref_tick(vref_tick),
    .quarter_tick(quarter_tick), .cpu_tick(cpu_tick)
  );

  typedef struct {
    logic [4:0] exp;   // {uart, timer, vref, quarter, cpu}
    string      ctx;   // requirement context override, "" for normal counting
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  int unsigned k = 0;
  int sel_act = 0;
  bit done = 1'b0;

  task automatic step(input bit r, input bit en, input logic [1:0] sel);
    item_t it;
    @(negedge clk);
    rst = r; run = en; rate_sel = sel;
    if (r) begin
      k = 0; sel_act = 0;
      it.exp = '0; it.ctx = "R1";
    end else if (!en) begin
      it.exp = '0; it.ctx = "R8";
    end else begin
      k++;
      it.exp[4] = (k % 20) == 0;
      it.exp[3] = (k % 31) == 0;
      it.exp[2] = (k % 18) == 0;
      it.exp[1] = (k % 4) == 0;
      it.exp[0] = (k % (8 << sel_act)) == 0;
      if ((k % 64) == 0) sel_act = int'(sel);
      it.ctx = "";
    end
    q.push_back(it);
  endtask

  task automatic cmp(input logic act, input logic ex, input string tag);
    checks++;
    if (act !== ex) begin
      errors++;
      $display("FAIL %s at t=%0t: actual=%b expected=%b", tag, $time, act, ex);
    end
  endtask

  // Monitor: pops one expectation per edge, samples mid-cycle
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        cmp(uart_tick,    it.exp[4], it.ctx != "" ? it.ctx : "R2 R9 uart");
        cmp(timer_tick,   it.exp[3], it.ctx != "" ? it.ctx : "R3 R9 timer");
        cmp(vref_tick,    it.exp[2], it.ctx != "" ? it.ctx : "R4 R9 vref");
        cmp(quarter_tick, it.exp[1], it.ctx != "" ? it.ctx : "R5 R9 quarter");
        cmp(cpu_tick,     it.exp[0], it.ctx != "" ? it.ctx : "R6 R7 cpu");
      end
    end
  end

  // Driver: scenarios
  initial begin
    for (int i = 0; i < 4; i++) step(1, 0, 2'd0);           // R1 reset
    for (int i = 0; i < 200; i++) step(0, 1, 2'd0);         // R6 code 0
    for (int i = 0; i < 30; i++) step(0, 1, 2'd2);          // R7 request mid-frame
    for (int i = 0; i < 300; i++) step(0, 1, 2'd2);         // R6 code 2
    for (int i = 0; i < 7; i++) step(0, 0, 2'd3);           // R8 pause mid-period
    for (int i = 0; i < 300; i++) step(0, 1, 2'd3);         // R6 code 3
    for (int i = 0; i < 400; i++) begin                     // R7 select toggled every cycle
      step(0, (i % 9) != 4, 2'(i));                         // R8 short stalls
    end
    for (int i = 0; i < 300; i++) step(0, 1, 2'd1);         // R6 code 1
    for (int i = 0; i < 3; i++) step(1, 1, 2'd3);           // R1 reset mid-run
    for (int i = 0; i < 1300; i++) step(0, 1, 2'd0);        // R2 R3 R4 long run
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule